// File: doc/BRIEF.md
# Power-Down Clock Controller

This block decides when the internal clocks of a set of on-chip functions may run and when the crystal oscillator must stay powered. A power-down request comes from a software bit or from an external pin. The pin counts only while its pin-function select bit configures it as a power-down input. While a request is active, every function's clock enable is held low. An option bit picks the depth of the power-down. In the shallow depth only the clocks stop. In the deep depth the crystal oscillator is also switched off.

Leaving a shallow power-down is immediate. Leaving a deep power-down first restarts the oscillator. The block then counts a fixed number of time-base ticks so the crystal can settle, and only after that does it release the clocks. The tick input is a slow, already-divided time base that stands in for the real millisecond-scale settling time. Outside power-down, each function's clock enable follows that function's own enable bit. Register contents elsewhere are never reset by this block: it only gates clocks, and the gated state holds.

Top module: `pwrdn_clk_ctrl`

## Requirements
- R1: A power-down request is `sw_pd OR (pd_pin AND NOT pin_is_cs)`. On the clock edge that samples an active request, the block enters power-down: from the next cycle `ready` is 0 and every `clk_en` bit is 0.
- R2: While `pin_is_cs` is 1, the level of `pd_pin` has no effect: `ready`, `clk_en` and `xtal_en` behave as if `pd_pin` were 0.
- R3: `xtal_mode` is sampled on entry to power-down. When the sampled value is 1 (deep), `xtal_en` is 0 for as long as the request lasts. When it is 0 (shallow), `xtal_en` stays 1.
- R4: After a shallow power-down, the edge that samples the request as inactive restores the block: from the next cycle `ready` is 1 and `clk_en` equals `func_en`, with no wait.
- R5: After a deep power-down, the edge that samples the request as inactive sets `xtal_en` to 1 while `ready` and `clk_en` stay 0. The block then counts `STAB_TICKS` cycles with `tick`=1. The edge that samples the `STAB_TICKS`-th tick makes `ready` 1 and releases the clocks from the next cycle.
- R6: A request that arrives during the settling wait aborts the wait. The block re-enters power-down and re-samples `xtal_mode`. A later release restarts the full count of `STAB_TICKS` ticks.
- R7: While the block is running, `clk_en[i]` equals `func_en[i]` for each function `i`. Clearing one enable bit stops only that function's clock.
- R8: After a synchronous active-low reset the block is running: `ready`=1, `xtal_en`=1, `clk_en`=`func_en`. The settling counter never exceeds `STAB_TICKS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the settling time base |
| pd_pin | input | 1 | External power-down pin level, active high |
| sw_pd | input | 1 | Software power-down bit |
| xtal_mode | input | 1 | Depth option: 1 also stops the crystal, 0 stops clocks only |
| pin_is_cs | input | 1 | 1: shared pin is a chip-select output, so its level is ignored |
| func_en | input | N_FUNC | Per-function enable bits |
| clk_en | output | N_FUNC | Per-function clock enables |
| xtal_en | output | 1 | Crystal oscillator enable |
| ready | output | 1 | High while clocks are released |

## Verification
The assertions check on every cycle that a software request always takes `ready` low on the following cycle. They also check that no clock runs while the crystal is off, that a request on the pin alone is harmless while the pin is configured as chip-select, that each kind of release moves to the correct next state, and that the settling counter stays in range. Only the bench's scenarios can show the exact cycle on which `ready` returns after the `STAB_TICKS`-th tick. The same holds for restarting the count after an aborted wait, for capturing `xtal_mode` at entry, and for per-function gating, because each of these depends on a history of inputs and not on one cycle.

// File: rtl/pdc_pkg.sv
// Shared types for the power-down clock controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pdc_pkg;
    typedef enum logic [1:0] {
        PD_RUN    = 2'd0,   // clocks released
        PD_HALT   = 2'd1,   // power-down active
        PD_SETTLE = 2'd2    // crystal restarting, clocks still held
    } pd_state_t;
endpackage

// File: rtl/pdc_request.sv
// Merges the power-down sources into one request.
// Assumes: all inputs are synchronous to the control clock.
module pdc_request (
    input  logic pd_pin,
    input  logic sw_pd,
    input  logic pin_is_cs,
    output logic pd_req
);
    // Pin counts only while it is configured as a power-down input.
    always_comb pd_req = sw_pd | (pd_pin & ~pin_is_cs);
endmodule

// File: rtl/pdc_sequencer.sv
// Power-down state machine with crystal settling counter.
// Assumes: tick is a one-cycle pulse; STAB_TICKS >= 1.
module pdc_sequencer
    import pdc_pkg::*;
#(
    parameter int STAB_TICKS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      pd_req,
    input  logic      xtal_mode,
    output pd_state_t state,
    output logic      deep_q
);
    localparam int CW = (STAB_TICKS > 1) ? $clog2(STAB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_TICKS - 1);

    logic [CW-1:0] cnt;

    // Next state, depth capture and settling count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PD_RUN;
            deep_q <= 1'b0;
            cnt    <= '0;
        end else begin
            unique case (state)
                PD_RUN: begin
                    cnt <= '0;
                    if (pd_req) begin
                        state  <= PD_HALT;
                        deep_q <= xtal_mode;
                    end
                end
                PD_HALT: begin
                    cnt <= '0;
                    if (!pd_req)
                        state <= deep_q ? PD_SETTLE : PD_RUN;
                end
                PD_SETTLE: begin
                    if (pd_req) begin
                        state  <= PD_HALT;
                        deep_q <= xtal_mode;
                        cnt    <= '0;
                    end else if (tick) begin
                        if (cnt == LAST) begin
                            state <= PD_RUN;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= PD_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5
    deep_exit_settles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_HALT && deep_q && !pd_req) |=> (state == PD_SETTLE));

    // R4
    shallow_exit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_HALT && !deep_q && !pd_req) |=> (state == PD_RUN));

    // R6
    settle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_SETTLE && pd_req) |=> (state == PD_HALT));
endmodule

// File: rtl/pdc_clk_gate.sv
// Derives per-function clock enables, crystal enable and ready flag.
// Assumes: state and deep_q come from pdc_sequencer.
module pdc_clk_gate
    import pdc_pkg::*;
#(
    parameter int N_FUNC = 3
) (
    input  pd_state_t         state,
    input  logic              deep_q,
    input  logic [N_FUNC-1:0] func_en,
    output logic [N_FUNC-1:0] clk_en,
    output logic              xtal_en,
    output logic              ready
);
    logic run;

    // Clocks may run only in the released state.
    always_comb run = (state == PD_RUN);

    genvar i;
    generate
        for (i = 0; i < N_FUNC; i++) begin : g_fn
            // Each function gated by its own enable bit.
            always_comb clk_en[i] = run & func_en[i];
        end
    endgenerate

    // Crystal is off only in a deep power-down.
    always_comb xtal_en = !((state == PD_HALT) && deep_q);

    // Ready mirrors the released state.
    always_comb ready = run;
endmodule

// File: rtl/pwrdn_clk_ctrl.sv
// Top of the power-down clock controller.
// Assumes: synchronous inputs; tick from a slow time base.
module pwrdn_clk_ctrl
    import pdc_pkg::*;
#(
    parameter int N_FUNC     = 3,
    parameter int STAB_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pd_pin,
    input  logic              sw_pd,
    input  logic              xtal_mode,
    input  logic              pin_is_cs,
    input  logic [N_FUNC-1:0] func_en,
    output logic [N_FUNC-1:0] clk_en,
    output logic              xtal_en,
    output logic              ready
);
    logic      pd_req;
    pd_state_t state;
    logic      deep_q;

    pdc_request u_req (
        .pd_pin    (pd_pin),
        .sw_pd     (sw_pd),
        .pin_is_cs (pin_is_cs),
        .pd_req    (pd_req)
    );

    pdc_sequencer #(.STAB_TICKS(STAB_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pd_req    (pd_req),
        .xtal_mode (xtal_mode),
        .state     (state),
        .deep_q    (deep_q)
    );

    pdc_clk_gate #(.N_FUNC(N_FUNC)) u_gate (
        .state   (state),
        .deep_q  (deep_q),
        .func_en (func_en),
        .clk_en  (clk_en),
        .xtal_en (xtal_en),
        .ready   (ready)
    );

    // R1
    sw_request_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pd |=> !ready);

    // R2
    pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pin_is_cs && !sw_pd) |=> ready);

    // R3
    no_clock_without_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_en |-> (clk_en == '0 && !ready));
endmodule

// File: tb/pwrdn_clk_ctrl_bench.sv
module pwrdn_clk_ctrl_bench;
    localparam int NF = 3;
    localparam int ST = 5;

    logic clk = 1'b0;
    logic rst_n, tick, pd_pin, sw_pd, xtal_mode, pin_is_cs;
    logic [NF-1:0] func_en, clk_en;
    logic xtal_en, ready;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pwrdn_clk_ctrl #(.N_FUNC(NF), .STAB_TICKS(ST)) u_pwrdn_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pd_pin(pd_pin), .sw_pd(sw_pd),
        .xtal_mode(xtal_mode), .pin_is_cs(pin_is_cs), .func_en(func_en),
        .clk_en(clk_en), .xtal_en(xtal_en), .ready(ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(1);
        chk("R8 ready after reset", ready, 1);
        chk("R8 xtal_en after reset", xtal_en, 1);
        chk("R8 clk_en after reset", clk_en, 3'b111);
    endtask

    task automatic t_shallow();
        xtal_mode = 1'b0; sw_pd = 1'b1; step(1);
        chk("R1 ready in power-down", ready, 0);
        chk("R1 clk_en in power-down", clk_en, 0);
        chk("R3 shallow keeps crystal", xtal_en, 1);
        xtal_mode = 1'b1; step(2);
        chk("R3 depth latched at entry", xtal_en, 1);
        sw_pd = 1'b0; xtal_mode = 1'b0; step(1);
        chk("R4 ready right after shallow exit", ready, 1);
        chk("R4 clk_en right after shallow exit", clk_en, 3'b111);
    endtask

    task automatic t_pin();
        pin_is_cs = 1'b0; pd_pin = 1'b1; step(1);
        chk("R1 pin request halts", ready, 0);
        pd_pin = 1'b0; step(1);
        chk("R4 pin release resumes", ready, 1);
        pin_is_cs = 1'b1; pd_pin = 1'b1; xtal_mode = 1'b1; step(3);
        chk("R2 pin ignored: ready", ready, 1);
        chk("R2 pin ignored: xtal_en", xtal_en, 1);
        chk("R2 pin ignored: clk_en", clk_en, 3'b111);
        pd_pin = 1'b0; pin_is_cs = 1'b0; xtal_mode = 1'b0; step(1);
    endtask

    task automatic t_deep();
        xtal_mode = 1'b1; sw_pd = 1'b1; step(1);
        chk("R3 deep stops crystal", xtal_en, 0);
        pulse_ticks(ST + 1);
        chk("R5 ticks ignored while requested", ready, 0);
        sw_pd = 1'b0; step(1);
        chk("R5 crystal restarts on release", xtal_en, 1);
        chk("R5 clocks held at release", ready, 0);
        pulse_ticks(ST - 1);
        chk("R5 still held after ST-1 ticks", ready, 0);
        chk("R5 clk_en held after ST-1 ticks", clk_en, 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R5 ready after ST ticks", ready, 1);
        chk("R5 clk_en after ST ticks", clk_en, 3'b111);
        step(1);
    endtask

    task automatic t_abort();
        xtal_mode = 1'b1; sw_pd = 1'b1; step(1);
        sw_pd = 1'b0; step(1);
        pulse_ticks(ST - 2);
        sw_pd = 1'b1; step(1);
        chk("R6 abort re-halts crystal", xtal_en, 0);
        chk("R6 abort keeps ready low", ready, 0);
        sw_pd = 1'b0; step(1);
        pulse_ticks(ST - 1);
        chk("R6 count restarted after abort", ready, 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R6 ready after full recount", ready, 1);
        xtal_mode = 1'b0; step(1);
    endtask

    task automatic t_func();
        func_en = 3'b101; step(1);
        chk("R7 single function stopped", clk_en, 3'b101);
        func_en = 3'b010; step(1);
        chk("R7 others follow own bits", clk_en, 3'b010);
        chk("R7 ready unaffected", ready, 1);
        func_en = 3'b111; step(1);
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; pd_pin = 1'b0; sw_pd = 1'b0;
        xtal_mode = 1'b0; pin_is_cs = 1'b0; func_en = 3'b111;
        step(1);
        t_reset();
        t_shallow();
        t_pin();
        t_deep();
        t_abort();
        t_func();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule